// File: doc/BRIEF.md
# Reset-Time Boot Path and Core Clock Mode Selector

This block decides, once per reset, where the core begins execution and how fast it runs. It holds a small non-volatile-style store: an 8-bit boot status byte and a sticky clock-doubling configuration bit. Command strobes can lower status bits, clear the byte outright, or program the configuration bit. A full-erase strobe returns both to their erased defaults. The configuration bit cannot otherwise be cleared, and status bits cannot otherwise be raised.

When the synchronized functional reset deasserts, the block samples three pin straps and the stored state. From these it fixes a boot-select flag and a start address, which hold until the next deassertion. The clock-mode output merges the configuration bit captured at that moment with a live software doubling bit. The power-on input `por_n` stands for the store being freshly erased at power-up. It also clears every output register.

Top module: `boot_clk_sel`

## Requirements
- R1: The boot decision is captured only on the third rising clock edge after `rst_n` is released, because it passes a two-flop reset synchronizer and an edge detector. Strap changes made while the block is running have no effect until the next release.
- R2: A captured status byte of exactly 8'h00 gives `boot_sel`=0 and `start_addr`=16'h0000. Any nonzero byte gives `boot_sel`=1 and `start_addr`=BOOT_VEC, which defaults to 16'hFC00.
- R3: While `por_n` is low, all three outputs read 0, the status byte becomes 8'hFF and the configuration bit becomes 0 (erased).
- R4: `cmd_status_wr` replaces the status byte with its bitwise AND with `cmd_wr_data`, and `cmd_status_clr` sets it to 8'h00. No command other than erase can set a status bit back to 1.
- R5: Boot is forced (`boot_sel`=1, `start_addr`=BOOT_VEC) whatever the status byte, when the synchronized straps at capture are `strap_lo_n`=0, `strap_hi_a`=1 and `strap_hi_b`=1. Any other strap pattern leaves the decision to the status byte.
- R6: `cmd_cfg_prog` sets the configuration bit, which takes effect at the next capture. `clk6_mode`=1 means 6-clock mode and 0 means 12-clock mode. One cycle after each edge, `clk6_mode` equals the captured configuration bit OR `sw_x2`.
- R7: After `cmd_erase`, the next capture sees the configuration bit erased, so with `sw_x2`=0 the block runs in 12-clock mode (`clk6_mode`=0).
- R8: Status or configuration commands issued while running leave `boot_sel` and `start_addr` unchanged until the next capture.
- R9: When `cmd_erase` arrives in the same cycle as any other command, the erase wins: the status byte is 8'hFF and the configuration bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| rst_n | input | 1 | Functional reset, active low, asynchronous assert |
| strap_lo_n | input | 1 | Strap that must be low to force boot |
| strap_hi_a | input | 1 | Strap that must be high to force boot |
| strap_hi_b | input | 1 | Second strap that must be high to force boot |
| sw_x2 | input | 1 | Software clock-doubling request |
| cmd_status_wr | input | 1 | Strobe: AND `cmd_wr_data` into the status byte |
| cmd_wr_data | input | 8 | Data for `cmd_status_wr` |
| cmd_status_clr | input | 1 | Strobe: set the status byte to 8'h00 |
| cmd_cfg_prog | input | 1 | Strobe: program the configuration bit |
| cmd_erase | input | 1 | Strobe: full erase of status byte and configuration bit |
| boot_sel | output | 1 | 1 = boot loader, 0 = user code |
| start_addr | output | 16 | Captured start address |
| clk6_mode | output | 1 | 1 = 6-clock mode, 0 = 12-clock mode |

## Verification
The boot decision is exercised with the erased byte, a cleared byte, partial AND writes that leave the byte nonzero and then zero it, and a write of all ones to a cleared byte. These patterns separate an exact-zero compare from a test on one bit, and an AND update from a plain overwrite. The force pattern is applied against a zero byte, next to the near-miss pattern with `strap_hi_a` low, and again while running. This shows that all three straps count and that sampling happens only at release. The clock mode is tried under all combinations of the configuration bit and `sw_x2`, including before and after the capture that follows programming, and with erase colliding with other commands.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int STAT_W = 8;
  typedef logic [STAT_W-1:0] stat_t;
  localparam stat_t STAT_ERASED = '1;
  localparam stat_t STAT_USER   = '0;

  typedef struct packed {
    logic lo_n;
    logic hi_a;
    logic hi_b;
  } strap_t;

  // zero status means user code
  function automatic logic stat_selects_user(input stat_t s);
    return (s == STAT_USER);
  endfunction

  // pin-strap override pattern
  function automatic logic strap_forces_boot(input strap_t p);
    return (!p.lo_n) && p.hi_a && p.hi_b;
  endfunction

  // flash-like write: bits may only fall
  function automatic stat_t stat_merge(input stat_t cur, input stat_t wr);
    return cur & wr;
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[0] <= RST_VAL;
          else         stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) stg[g] <= RST_VAL;
          else         stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bcs_store.sv
module bcs_store
  import bcs_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  cmd_status_wr,
  input  stat_t cmd_wr_data,
  input  logic  cmd_status_clr,
  input  logic  cmd_cfg_prog,
  input  logic  cmd_erase,
  output stat_t status_q,
  output logic  cfg_q
);
  stat_t status_d;
  logic  cfg_d;

  always_comb begin
    status_d = status_q;
    cfg_d    = cfg_q;
    if (cmd_erase) begin
      status_d = STAT_ERASED;
      cfg_d    = 1'b0;
    end else begin
      if (cmd_status_wr)  status_d = stat_merge(status_d, cmd_wr_data);
      if (cmd_status_clr) status_d = STAT_USER;
      if (cmd_cfg_prog)   cfg_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      status_q <= STAT_ERASED;
      cfg_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      cfg_q    <= cfg_d;
    end
  end

  p_no_raise_r4: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_erase |=> ((status_q & ~$past(status_q)) == '0));

  // also covers R9: erase beats every other strobe
  p_erase_default_r3: assert property (@(posedge clk) disable iff (!por_n)
    cmd_erase |=> (status_q == STAT_ERASED) && !cfg_q);

  p_cfg_sticky_r6: assert property (@(posedge clk) disable iff (!por_n)
    cfg_q && !cmd_erase |=> cfg_q);
endmodule

// File: rtl/bcs_decide.sv
module bcs_decide
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] USER_VEC = '0,
  parameter logic [ADDR_W-1:0] BOOT_VEC = 16'hFC00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              cap_evt,
  input  strap_t            straps,
  input  stat_t             status_q,
  input  logic              cfg_q,
  input  logic              sw_x2,
  output logic              boot_sel,
  output logic [ADDR_W-1:0] start_addr,
  output logic              clk6_mode
);
  logic boot_now;
  logic cfg_cap_q;

  assign boot_now = strap_forces_boot(straps) || !stat_selects_user(status_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      boot_sel   <= 1'b0;
      start_addr <= USER_VEC;
      cfg_cap_q  <= 1'b0;
    end else if (cap_evt) begin
      boot_sel   <= boot_now;
      start_addr <= boot_now ? BOOT_VEC : USER_VEC;
      cfg_cap_q  <= cfg_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) clk6_mode <= 1'b0;
    else        clk6_mode <= cfg_cap_q | sw_x2;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !cap_evt |=> $stable(boot_sel) && $stable(start_addr));

  p_addr_match_r2: assert property (@(posedge clk) disable iff (!por_n)
    boot_sel |-> start_addr == BOOT_VEC);

  p_force_r5: assert property (@(posedge clk) disable iff (!por_n)
    cap_evt && strap_forces_boot(straps) |=> boot_sel);

  p_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
    cfg_cap_q |=> clk6_mode);
endmodule

// File: rtl/boot_clk_sel.sv
module boot_clk_sel
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BOOT_VEC = 16'hFC00
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              strap_lo_n,
  input  logic              strap_hi_a,
  input  logic              strap_hi_b,
  input  logic              sw_x2,
  input  logic              cmd_status_wr,
  input  logic [STAT_W-1:0] cmd_wr_data,
  input  logic              cmd_status_clr,
  input  logic              cmd_cfg_prog,
  input  logic              cmd_erase,
  output logic              boot_sel,
  output logic [ADDR_W-1:0] start_addr,
  output logic              clk6_mode
);
  localparam int STRAP_W = $bits(strap_t);

  logic   rst_sync_n;
  logic   rst_seen_q;
  logic   cap_evt;
  strap_t strap_raw;
  strap_t strap_sync;
  stat_t  status_q;
  logic   cfg_q;

  assign strap_raw = '{lo_n: strap_lo_n, hi_a: strap_hi_a, hi_b: strap_hi_b};

  bcs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n));

  bcs_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_strap_sync (
    .clk(clk), .arst_n(por_n), .d(strap_raw), .q(strap_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_seen_q <= 1'b0;
    else        rst_seen_q <= rst_sync_n;
  end

  assign cap_evt = rst_sync_n && !rst_seen_q;

  bcs_store i_store (
    .clk(clk), .por_n(por_n),
    .cmd_status_wr(cmd_status_wr), .cmd_wr_data(cmd_wr_data),
    .cmd_status_clr(cmd_status_clr), .cmd_cfg_prog(cmd_cfg_prog),
    .cmd_erase(cmd_erase), .status_q(status_q), .cfg_q(cfg_q));

  bcs_decide #(.ADDR_W(ADDR_W), .BOOT_VEC(BOOT_VEC)) i_decide (
    .clk(clk), .por_n(por_n), .cap_evt(cap_evt), .straps(strap_sync),
    .status_q(status_q), .cfg_q(cfg_q), .sw_x2(sw_x2),
    .boot_sel(boot_sel), .start_addr(start_addr), .clk6_mode(clk6_mode));

  p_cap_single_r1: assert property (@(posedge clk) disable iff (!por_n)
    cap_evt |=> !cap_evt);
endmodule

// File: tb/test_boot_clk_sel.sv
module test_boot_clk_sel;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic strap_lo_n = 1'b1, strap_hi_a = 1'b0, strap_hi_b = 1'b0;
  logic sw_x2 = 1'b0;
  logic cmd_status_wr = 1'b0, cmd_status_clr = 1'b0, cmd_cfg_prog = 1'b0, cmd_erase = 1'b0;
  logic [7:0] cmd_wr_data = 8'h00;
  logic boot_sel, clk6_mode;
  logic [15:0] start_addr;

  localparam logic [15:0] BOOT_A = 16'hFC00;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boot_clk_sel i_boot_clk_sel (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .strap_lo_n(strap_lo_n), .strap_hi_a(strap_hi_a), .strap_hi_b(strap_hi_b),
    .sw_x2(sw_x2), .cmd_status_wr(cmd_status_wr), .cmd_wr_data(cmd_wr_data),
    .cmd_status_clr(cmd_status_clr), .cmd_cfg_prog(cmd_cfg_prog), .cmd_erase(cmd_erase),
    .boot_sel(boot_sel), .start_addr(start_addr), .clk6_mode(clk6_mode));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // boot outputs checked together: user -> 0/0000, boot -> 1/FC00
  task automatic check_boot(input string req, input logic exp_boot);
    check(req, {31'd0, boot_sel}, {31'd0, exp_boot});
    check(req, {16'd0, start_addr}, exp_boot ? {16'd0, BOOT_A} : 32'd0);
  endtask

  task automatic cycle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    cycle(3);
    rst_n = 1'b1;
    cycle(5);
  endtask

  task automatic set_straps(input logic a, input logic b, input logic c);
    strap_lo_n = a; strap_hi_a = b; strap_hi_b = c;
    cycle(3);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk) begin cmd_status_wr = 1'b1; cmd_wr_data = d; end
    @(negedge clk) cmd_status_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) cmd_status_clr = 1'b1;
    @(negedge clk) cmd_status_clr = 1'b0;
  endtask

  task automatic pulse_prog();
    @(negedge clk) cmd_cfg_prog = 1'b1;
    @(negedge clk) cmd_cfg_prog = 1'b0;
  endtask

  task automatic pulse_erase();
    @(negedge clk) cmd_erase = 1'b1;
    @(negedge clk) cmd_erase = 1'b0;
  endtask

  task automatic t_power_on();
    cycle(3);
    por_n = 1'b1;
    cycle(3);
    check("R3 reset boot_sel", {31'd0, boot_sel}, 32'd0);
    check("R3 reset start_addr", {16'd0, start_addr}, 32'd0);
    check("R3 reset clk6_mode", {31'd0, clk6_mode}, 32'd0);
    rst_n = 1'b1;
    cycle(5);
    check_boot("R3 R2 erased status boots loader", 1'b1);
    check("R7 erased cfg 12-clock", {31'd0, clk6_mode}, 32'd0);
  endtask

  task automatic t_release_timing();
    // R1: capture lands on the third edge after release
    pulse_clr();
    @(negedge clk) rst_n = 1'b0;
    cycle(3);
    rst_n = 1'b1;
    cycle(2);
    check("R1 no capture after two edges", {31'd0, boot_sel}, 32'd1);
    cycle(1);
    check_boot("R1 capture after third edge", 1'b0);
  endtask

  task automatic t_clear_live();
    pulse_erase();
    do_reset();
    check_boot("R2 erased boot", 1'b1);
    pulse_clr();
    cycle(2);
    check_boot("R8 clear while running keeps boot", 1'b1);
    do_reset();
    check_boot("R2 zero status selects user", 1'b0);
  endtask

  task automatic t_no_raise();
    pulse_wr(8'hFF);
    do_reset();
    check_boot("R4 writing FF cannot raise status", 1'b0);
  endtask

  task automatic t_and_write();
    pulse_erase();
    pulse_wr(8'h5A);
    do_reset();
    check_boot("R4 FF AND 5A nonzero", 1'b1);
    pulse_wr(8'hA5);
    do_reset();
    check_boot("R4 5A AND A5 zero", 1'b0);
  endtask

  task automatic t_straps();
    set_straps(1'b0, 1'b1, 1'b1);
    do_reset();
    check_boot("R5 force pattern boots", 1'b1);
    set_straps(1'b0, 1'b0, 1'b1);
    do_reset();
    check_boot("R5 near-miss pattern no force", 1'b0);
    set_straps(1'b0, 1'b1, 1'b1);
    cycle(4);
    check_boot("R1 strap change while running ignored", 1'b0);
    set_straps(1'b1, 1'b0, 1'b0);
    do_reset();
  endtask

  task automatic t_mode();
    sw_x2 = 1'b1; cycle(2);
    check("R6 cfg erased x2=1", {31'd0, clk6_mode}, 32'd1);
    sw_x2 = 1'b0; cycle(2);
    check("R6 cfg erased x2=0", {31'd0, clk6_mode}, 32'd0);
    pulse_prog();
    cycle(2);
    check("R6 cfg waits for capture", {31'd0, clk6_mode}, 32'd0);
    do_reset();
    check("R6 cfg programmed x2=0", {31'd0, clk6_mode}, 32'd1);
    pulse_erase();
    do_reset();
    check("R7 erase restores 12-clock", {31'd0, clk6_mode}, 32'd0);
    check_boot("R7 erase restores boot", 1'b1);
  endtask

  task automatic t_collide();
    pulse_clr();
    @(negedge clk) begin cmd_erase = 1'b1; cmd_status_clr = 1'b1; cmd_cfg_prog = 1'b1; end
    @(negedge clk) begin cmd_erase = 1'b0; cmd_status_clr = 1'b0; cmd_cfg_prog = 1'b0; end
    do_reset();
    check_boot("R9 erase wins over clear", 1'b1);
    check("R9 erase wins over cfg program", {31'd0, clk6_mode}, 32'd0);
  endtask

  initial begin
    t_power_on();
    t_release_timing();
    t_clear_live();
    t_no_raise();
    t_and_write();
    t_straps();
    t_mode();
    t_collide();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule